// File: doc/BRIEF.md
# Misaligned Access Bus Splitter

This block sits between a load/store unit and a 64-bit external data bus made of eight byte lanes. A request carries a byte address, a transfer length of 1, 2, 4 or 8 bytes, a read/write flag and right-justified write data. The block turns each request into one or more bus transactions. Each transaction carries a 3-bit size code, the byte address it starts at and one enable bit per byte lane. The block moves write bytes onto the lanes they belong to. On reads it gathers the requested bytes from the lanes into one right-justified result.

An access whose bytes all lie inside one aligned 32-bit word goes out as a single transfer on the lanes where those bytes sit, even when it is misaligned. An access that runs across a word boundary is cut at each boundary it meets, and the pieces are issued one after another. An aligned 8-byte access is the one exception: it goes out as one full-width transfer.

Both the request side and the bus side use a valid/ready handshake. A transaction waits on the bus until it is acknowledged. A single completion pulse marks the end of the whole request.

Top module: `misaligned_bus_splitter`

## Requirements
- R1: An access whose bytes all lie in one aligned 32-bit word is issued as exactly one bus transaction, and busAddr equals the request address. This holds for misaligned accesses too, such as 2 bytes at an odd address.
- R2: An access that crosses a 32-bit word boundary is cut at every word boundary it crosses. The first transaction runs from the request address to the first boundary, and each later one starts at the next word address. A misaligned 8-byte access therefore takes two or three transactions.
- R3: busSize gives the number of bytes in the transaction: 001, 010, 011 and 100 mean 1, 2, 3 and 4 bytes, and 000 means 8 bytes.
- R4: An 8-byte request whose address has low three bits 000 is issued as one transaction with busSize 000 and all eight lane enables set. A size code of 000 only ever appears with low address bits 000.
- R5: Lane L is enabled by busLaneEn[L]. The enabled lanes are contiguous: they start at lane busAddr[2:0] and there are as many as the transaction has bytes. The enables never cover lanes in both halves of the bus, except for the full-width transfer.
- R6: Write data arrives right-justified in reqWdata, with the most significant byte belonging to the lowest address. Lane L travels on busWdata[63-8L:56-8L], and each enabled lane carries the request byte whose address is (busAddr with low three bits cleared) + L. Lanes that are not enabled are undefined.
- R7: On reads, the bytes on enabled lanes are taken from busRdata in the cycle busReady is high, and all other lanes are ignored. rspRdata returns the bytes of every transaction assembled right-justified, with the lowest address most significant and the unused upper bits zero. After a write, rspRdata is zero.
- R8: From the cycle busValid rises until the cycle busReady is sampled high, busValid, busAddr, busSize and busLaneEn stay unchanged. The next transaction of a split access is presented in the cycle after the acknowledgement.
- R9: rspValid is high for exactly one cycle per request, in the cycle after the last transaction is acknowledged. reqReady is low from request acceptance until that pulse has ended.
- R10: After reset, reqReady is 1 and busValid and rspValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqSize | input | 2 | Length code: 0=1, 1=2, 2=4, 3=8 bytes |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 64 | Right-justified write data |
| busValid | output | 1 | Bus transaction present |
| busReady | input | 1 | Bus acknowledges the transaction (read data valid) |
| busAddr | output | ADDR_W | Start byte address of the transaction |
| busSize | output | 3 | Byte count code of the transaction |
| busLaneEn | output | 8 | Per-lane enables, bit L for lane L |
| busWrite | output | 1 | Transaction direction |
| busWdata | output | 64 | Lane-aligned write data, lane 0 in bits 63:56 |
| busRdata | input | 64 | Lane-aligned read data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 64 | Assembled right-justified read result |

## Verification
The hardest case to reach from the ports is a misaligned 8-byte read that needs three transactions. It is even harder when the bus stalls each of them for a different number of cycles while the unused lanes carry junk. Here the running byte count, the step across two word boundaries and the merge of three partial lane sets all have to line up. Directed requests at offsets 1, 2, 3 and 5 reach this case on purpose. Random traffic over all lengths and offsets, with random acknowledge delays and random fill on the unused lanes, drives it repeatedly.

// File: rtl/msb_pkg.sv
package msb_pkg;
  localparam int LANES  = 8;
  localparam int DATA_W = LANES * 8;

  // strobes from the sequencer to the lane datapath
  typedef struct packed {
    logic load;   // capture a new request
    logic step;   // current transaction acknowledged
  } msbStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_RSP  = 2'd2
  } msbState_t;
endpackage

// File: rtl/msb_ctrl.sv
module msb_ctrl
  import msb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        busReady,
  input  logic        lastBeat,
  output logic        reqReady,
  output logic        busValid,
  output logic        rspValid,
  output msbStrobes_t strobes
);
  msbState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    strobes      = '0;
    reqReady     = 1'b0;
    busValid     = 1'b0;
    rspValid     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobes.load = 1'b1;
          stateNext    = ST_BUS;
        end
      end
      ST_BUS: begin
        busValid = 1'b1;
        if (busReady) begin
          strobes.step = 1'b1;
          if (lastBeat) stateNext = ST_RSP;
        end
      end
      ST_RSP: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R8: an unacknowledged transaction stays on the bus
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid);
  // R9: completion is a single-cycle pulse
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  // R9: completion only follows an acknowledgement
  p_after_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(busValid && busReady));
  // R9: no new request is taken while a transaction is pending
  p_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !reqReady);
endmodule

// File: rtl/msb_dpath.sv
module msb_dpath
  import msb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  msbStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busSize,
  output logic [LANES-1:0]  busLaneEn,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              lastBeat
);
  localparam int CNT_W = $clog2(LANES) + 1;
  localparam int SH_W  = CNT_W + 3;

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  nBytes, remBytes, doneBytes;
  logic              wideMode, writeReg;
  logic [DATA_W-1:0] wAlign, rAcc;

  logic [CNT_W-1:0]  wordRoom, chunk, reqBytes;
  logic [2:0]        laneStart;
  logic [LANES:0]    fill;
  logic [DATA_W-1:0] topMask, picked, rNext;

  assign reqBytes  = CNT_W'(1) << reqSize;
  assign laneStart = curAddr[2:0];
  assign wordRoom  = CNT_W'(4) - CNT_W'(curAddr[1:0]);
  assign chunk     = wideMode ? CNT_W'(LANES)
                   : ((remBytes < wordRoom) ? remBytes : wordRoom);
  assign fill      = ((LANES+1)'(1) << chunk) - (LANES+1)'(1);
  assign lastBeat  = (remBytes == chunk);

  assign busAddr   = curAddr;
  assign busSize   = chunk[2:0];
  assign busLaneEn = fill[LANES-1:0] << laneStart;
  assign busWrite  = writeReg;
  assign busWdata  = (wAlign << {doneBytes, 3'b000}) >> {laneStart, 3'b000};

  // left-justify the lanes of this transaction, keep only its bytes
  assign topMask = ~({DATA_W{1'b1}} >> {chunk, 3'b000});
  assign picked  = (busRdata << {laneStart, 3'b000}) & topMask;
  assign rNext   = rAcc | (picked >> {doneBytes, 3'b000});
  assign rspRdata = rAcc >> SH_W'({CNT_W'(LANES) - nBytes, 3'b000});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      nBytes    <= '0;
      remBytes  <= '0;
      doneBytes <= '0;
      wideMode  <= 1'b0;
      writeReg  <= 1'b0;
      wAlign    <= '0;
      rAcc      <= '0;
    end else if (strobes.load) begin
      curAddr   <= reqAddr;
      nBytes    <= reqBytes;
      remBytes  <= reqBytes;
      doneBytes <= '0;
      wideMode  <= (reqSize == 2'd3) && (reqAddr[2:0] == 3'd0);
      writeReg  <= reqWrite;
      wAlign    <= reqWdata << {CNT_W'(LANES) - reqBytes, 3'b000};
      rAcc      <= '0;
    end else if (strobes.step) begin
      curAddr   <= curAddr + ADDR_W'(chunk);
      remBytes  <= remBytes - chunk;
      doneBytes <= doneBytes + chunk;
      if (!writeReg) rAcc <= rNext;
    end
  end

  // R5: lanes of one transaction never straddle the word halves
  p_one_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    busLaneEn[7:4] == 4'd0 || busLaneEn[3:0] == 4'd0 || busLaneEn == 8'hFF);
  // R4: full-width code only at a doubleword-aligned address
  p_dw_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    busSize == 3'd0 && busLaneEn != 8'd0 |-> busAddr[2:0] == 3'd0);
  // R2: after a non-final acknowledgement the next piece is word aligned
  p_next_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step && !lastBeat |=> busAddr[1:0] == 2'd0);
endmodule

// File: rtl/misaligned_bus_splitter.sv
module misaligned_bus_splitter
  import msb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [63:0]       reqWdata,
  output logic              busValid,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busSize,
  output logic [7:0]        busLaneEn,
  output logic              busWrite,
  output logic [63:0]       busWdata,
  input  logic [63:0]       busRdata,
  output logic              rspValid,
  output logic [63:0]       rspRdata
);
  msbStrobes_t strobes;
  logic        lastBeat;

  msb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busReady(busReady),
    .lastBeat(lastBeat), .reqReady(reqReady), .busValid(busValid),
    .rspValid(rspValid), .strobes(strobes)
  );

  msb_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .busRdata(busRdata), .busAddr(busAddr), .busSize(busSize),
    .busLaneEn(busLaneEn), .busWrite(busWrite), .busWdata(busWdata),
    .rspRdata(rspRdata), .lastBeat(lastBeat)
  );

  // R8: a waiting transaction keeps its address and lanes
  p_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> $stable(busAddr) && $stable(busLaneEn) && $stable(busSize));
endmodule

// File: tb/misaligned_bus_splitter_tb.sv
module misaligned_bus_splitter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, busReady = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [63:0] reqWdata = '0, busRdata = '0;
  logic        reqReady, busValid, busWrite, rspValid;
  logic [31:0] busAddr;
  logic [2:0]  busSize;
  logic [7:0]  busLaneEn;
  logic [63:0] busWdata, rspRdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  misaligned_bus_splitter dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .busValid(busValid), .busReady(busReady), .busAddr(busAddr), .busSize(busSize),
    .busLaneEn(busLaneEn), .busWrite(busWrite), .busWdata(busWdata),
    .busRdata(busRdata), .rspValid(rspValid), .rspRdata(rspRdata)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung (act %0d cycles, exp < 150000)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %h exp %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // expected read: bytes at addr..addr+n-1, lowest address most significant
  function automatic logic [63:0] expRead(input logic [31:0] a, input int n);
    logic [63:0] v = '0;
    for (int k = 0; k < n; k++) v = (v << 8) | 64'(memByte(a + 32'(k)));
    return v;
  endfunction

  task automatic doReq(input logic [31:0] a, input logic [1:0] sz,
                       input bit wr, input logic [63:0] wd, input bit longStall);
    int n = 1 << sz;
    int rem = n;
    logic [31:0] cur = a;
    int beats = 0;
    logic [63:0] wdM;
    wdM = (n == 8) ? wd : (wd & ((64'd1 << (8 * n)) - 64'd1));
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr; reqWdata = wdM;
    @(negedge clk);
    reqValid = 1'b0; reqWdata = $urandom();
    chk(reqReady == 1'b0, "R9", "reqReady while busy", 64'(reqReady), 64'd0);
    while (rem > 0) begin
      int c;
      int dly;
      logic [7:0] en;
      logic [2:0] code;
      logic [31:0] sAddr;
      logic [7:0] sEn;
      if (n == 8 && a[2:0] == 3'd0) c = 8;
      else begin
        int room = 4 - int'(cur[1:0]);
        c = (rem < room) ? rem : room;
      end
      code = (c == 8) ? 3'b000 : 3'(c);
      en = 8'h00;
      for (int l = 0; l < 8; l++)
        if (l >= int'(cur[2:0]) && l < int'(cur[2:0]) + c) en[l] = 1'b1;
      chk(busValid == 1'b1, "R8", "busValid for next piece", 64'(busValid), 64'd1);
      chk(busAddr == cur, (beats == 0) ? "R1" : "R2", "busAddr", 64'(busAddr), 64'(cur));
      chk(busSize == code, (c == 8) ? "R4" : "R3", "busSize", 64'(busSize), 64'(code));
      chk(busLaneEn == en, "R5", "busLaneEn", 64'(busLaneEn), 64'(en));
      chk(busWrite == wr, "R6", "busWrite", 64'(busWrite), 64'(wr));
      if (wr) begin
        for (int l = 0; l < 8; l++) if (en[l]) begin
          int k = int'(({cur[31:3], 3'b000} + 32'(l)) - a);
          logic [7:0] eb = wdM[8*(n-1-k) +: 8];
          chk(busWdata[63-8*l -: 8] == eb, "R6", "write lane", 64'(busWdata[63-8*l -: 8]), 64'(eb));
        end
      end
      sAddr = busAddr; sEn = busLaneEn;
      dly = longStall ? 4 : int'($urandom_range(0, 3));
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(busValid && busAddr == sAddr && busLaneEn == sEn, "R8", "held while stalled",
            {busAddr, 24'd0, busLaneEn}, {sAddr, 24'd0, sEn});
      end
      for (int l = 0; l < 8; l++)
        busRdata[63-8*l -: 8] = en[l] ? memByte({cur[31:3], 3'b000} + 32'(l)) : 8'($urandom());
      busReady = 1'b1;
      @(negedge clk);
      busReady = 1'b0; busRdata = {$urandom(), $urandom()};
      cur = cur + 32'(c);
      rem = rem - c;
      beats++;
    end
    chk(beats == 1 || int'(a[1:0]) + n > 4, "R1", "beat count", 64'(beats), 64'd1);
    chk(rspValid == 1'b1, "R9", "completion pulse", 64'(rspValid), 64'd1);
    chk(busValid == 1'b0, "R2", "no extra piece", 64'(busValid), 64'd0);
    if (wr) chk(rspRdata == 64'd0, "R7", "write result", rspRdata, 64'd0);
    else    chk(rspRdata == expRead(a, n), "R7", "read merge", rspRdata, expRead(a, n));
    @(negedge clk);
    chk(rspValid == 1'b0 && reqReady == 1'b1, "R9", "single pulse then ready",
        {62'd0, rspValid, reqReady}, 64'd1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && busValid == 1'b0 && rspValid == 1'b0, "R10", "reset state",
        {61'd0, reqReady, busValid, rspValid}, 64'd4);
    // directed corner cases
    doReq(32'h0000_1001, 2'd1, 1'b0, '0, 1'b0);                 // R1 halfword at odd address
    doReq(32'h0000_1003, 2'd1, 1'b1, 64'hBEEF, 1'b1);           // R2 halfword crossing
    doReq(32'h0000_2000, 2'd3, 1'b0, '0, 1'b1);                 // R4 aligned doubleword read
    doReq(32'h0000_2008, 2'd3, 1'b1, 64'h0123456789ABCDEF, 1'b0); // R4 aligned write
    doReq(32'h0000_2004, 2'd3, 1'b0, '0, 1'b0);                 // R2 two word pieces
    doReq(32'h0000_3001, 2'd3, 1'b0, '0, 1'b1);                 // R2 three pieces
    doReq(32'h0000_3002, 2'd3, 1'b1, 64'hA1B2C3D4E5F60718, 1'b0);
    doReq(32'h0000_3003, 2'd3, 1'b0, '0, 1'b0);
    doReq(32'h0000_3005, 2'd3, 1'b0, '0, 1'b0);
    doReq(32'h0000_4006, 2'd2, 1'b1, 64'h11223344, 1'b0);       // R3 split 2+2
    doReq(32'h0000_4007, 2'd2, 1'b0, '0, 1'b0);                 // R3 split 1+3
    doReq(32'h0000_4005, 2'd0, 1'b1, 64'h77, 1'b0);             // R5 byte in lane 5
    doReq(32'hFFFF_FFFE, 2'd2, 1'b0, '0, 1'b0);                 // address wrap
    // constrained random traffic
    for (int i = 0; i < 400; i++)
      doReq($urandom(), 2'($urandom_range(0, 3)), 1'($urandom()),
            {$urandom(), $urandom()}, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule